// File: doc/BRIEF.md
# Debug Event Source Dispatcher

This block gathers debug events from three places in a processor core and turns each one into a single configured debug action. The places are an active-low external break-in pin, the execution of a software debug instruction, and core-register move instructions that reach a protected user register. Each of these sources owns a 4-bit event specifier. A small write-only configuration port programs the specifiers. A specifier enables its source, picks one of four actions (break-out pulse, CPU halt, breakpoint trap, interrupt request), and may add a suspend-out pulse that is issued together with the action.

The external pin passes through a synchronizer, and only its falling transition raises an event. An upstream routing enable gates that event. A software debug instruction counts only while debug mode is on; otherwise it is a no-op. A register access raises a protection event unless the address falls on one of nine dedicated debug registers. When several sources fire in one cycle, one action is issued and the others are dropped. Halt is a level that stays up until a resume pulse arrives. A cause code reports which source halted the core.

Top module: `dbg_event_dispatch`

## Requirements
- R1: After a synchronous reset, all action outputs, suspend_out and halt are low, halt_cause is 0, and all three specifiers read as disabled (value 0).
- R2: A specifier is 4 bits: bit 0 enable, bits 2:1 action code, bit 3 suspend request. Writing with cfg_we high loads cfg_wdata into specifier cfg_sel (0 = external, 1 = software, 2 = protection). The new value governs events starting in the next cycle. A write with cfg_sel = 3 changes nothing.
- R3: Action code 00 pulses brk_out, 10 pulses trap_req and 11 pulses irq_req, each for exactly one cycle, in the cycle after the event's inputs were presented. At most one of the three is high in any cycle.
- R4: suspend_out pulses in the same cycle as the issued action exactly when the winning specifier has its suspend bit set.
- R5: brk_in_n passes through a 2-stage synchronizer. A high-to-low transition yields an external event, and its action appears three clock edges after the edge that first samples the low level. The event is raised only if brk_route_en is high at that third edge. A level held low does not raise a second event.
- R6: With dbg_mode_en high, a valid instruction raises a software event in two cases: instr_word[0] = 0 and instr_word[15:0] = 16'h00A0, or instr_word[0] = 1 and instr_word = 32'h010000A1. With dbg_mode_en low, the instruction raises no event.
- R7: A valid register access raises a protection event unless creg_addr equals 16'hFD00 + 4*k for some k from 0 to 8. Any other address, including an unaligned address inside that window, raises the event.
- R8: Only sources whose specifier is enabled take part in arbitration. Priority runs external, then software, then protection, and lower-priority events in the same cycle are dropped. A disabled source produces no output.
- R9: Action code 01 sets halt high, and halt stays high until resume is sampled high. While halted, halt_cause holds 1 (external), 2 (software) or 3 (protection). Otherwise halt_cause is 0. A halt event while already halted keeps the earlier cause. A halt event in the same cycle as resume keeps halt high and records the new cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Specifier write strobe |
| cfg_sel | input | 2 | Specifier select (0 ext, 1 sw, 2 prot) |
| cfg_wdata | input | 4 | Specifier write value |
| brk_in_n | input | 1 | External break-in pin, active low, asynchronous |
| brk_route_en | input | 1 | Routing enable for the break-in path |
| dbg_mode_en | input | 1 | Debug mode enable |
| instr_valid | input | 1 | Instruction word is being executed |
| instr_word | input | 32 | Executed instruction encoding |
| creg_valid | input | 1 | Core-register move instruction executes |
| creg_addr | input | 16 | Core register address targeted by the move |
| resume | input | 1 | Releases a halt |
| brk_out | output | 1 | Break-out pulse |
| halt | output | 1 | CPU halt level |
| trap_req | output | 1 | Breakpoint trap request pulse |
| irq_req | output | 1 | Interrupt request pulse |
| suspend_out | output | 1 | Suspend-out pulse alongside an action |
| halt_cause | output | 2 | Source that caused the current halt |

## Verification
The hardest case to reach is a halt event that arrives in the same cycle as resume while the core is already halted, especially when a higher-priority source fires at the same moment. The stimulus first sets up a software-caused halt. It then aligns an external falling edge, timed three edges ahead, with a resume pulse and a protection access. A long randomized phase follows, with specifier rewrites, mode and routing changes and overlapping sources. A behavioural model compares every output on every clock throughout.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [1:0] {
    ACT_BRKOUT = 2'b00,
    ACT_HALT   = 2'b01,
    ACT_TRAP   = 2'b10,
    ACT_IRQ    = 2'b11
  } act_e;

  typedef struct packed {
    logic susp;
    act_e act;
    logic en;
  } spec_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_EXT  = 2'd1,
    CAUSE_SW   = 2'd2,
    CAUSE_PROT = 2'd3
  } cause_e;

  localparam int SRC_EXT  = 0;
  localparam int SRC_SW   = 1;
  localparam int SRC_PROT = 2;
  localparam int N_SRC    = 3;

endpackage

// File: rtl/dbg_ext_sync.sv
module dbg_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic route_en,
  output logic evt
);
  logic [STAGES-1:0] chain_q;
  logic              last_d_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_d_q <= 1'b1;
    else     last_d_q <= chain_q[STAGES-1];
  end

  assign evt = route_en & ~chain_q[STAGES-1] & last_d_q;

  // A falling transition cannot repeat on the next cycle
  assert_no_repeat_R5: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);

endmodule

// File: rtl/dbg_instr_decode.sv
module dbg_instr_decode #(
  parameter int          ADDR_W        = 16,
  parameter logic [15:0] SW16_CODE     = 16'h00A0,
  parameter logic [31:0] SW32_CODE     = 32'h0100_00A1,
  parameter int          DBGREG_BASE   = 'hFD00,
  parameter int          DBGREG_CNT    = 9,
  parameter int          DBGREG_STRIDE = 4
) (
  input  logic              dbg_mode_en,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic              creg_valid,
  input  logic [ADDR_W-1:0] creg_addr,
  output logic              sw_evt,
  output logic              prot_evt
);
  logic [DBGREG_CNT-1:0] hit;
  logic is16, is32;

  generate
    for (genvar k = 0; k < DBGREG_CNT; k++) begin : g_exempt
      localparam logic [ADDR_W-1:0] ADDR_K = ADDR_W'(DBGREG_BASE + k*DBGREG_STRIDE);
      assign hit[k] = (creg_addr == ADDR_K);
    end
  endgenerate

  assign is16 = ~instr_word[0] & (instr_word[15:0] == SW16_CODE);
  assign is32 =  instr_word[0] & (instr_word == SW32_CODE);

  assign sw_evt   = instr_valid & dbg_mode_en & (is16 | is32);
  assign prot_evt = creg_valid & ~(|hit);

endmodule

// File: rtl/dbg_spec_regs.sv
module dbg_spec_regs
  import dbg_pkg::*;
#(
  parameter int NS    = N_SRC,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [3:0]       cfg_wdata,
  output spec_t [NS-1:0]   spec_q
);
  generate
    for (genvar i = 0; i < NS; i++) begin : g_spec
      always_ff @(posedge clk) begin
        if (rst)
          spec_q[i] <= '0;
        else if (cfg_we && (cfg_sel == SEL_W'(i)))
          spec_q[i] <= spec_t'(cfg_wdata);
      end
    end
  endgenerate

  // Writes to an unused select leave every specifier unchanged
  assert_unused_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && (int'(cfg_sel) >= NS)) |=> $stable(spec_q));

endmodule

// File: rtl/dbg_event_dispatch.sv
module dbg_event_dispatch
  import dbg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [3:0]        cfg_wdata,
  input  logic              brk_in_n,
  input  logic              brk_route_en,
  input  logic              dbg_mode_en,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic              creg_valid,
  input  logic [ADDR_W-1:0] creg_addr,
  input  logic              resume,
  output logic              brk_out,
  output logic              halt,
  output logic              trap_req,
  output logic              irq_req,
  output logic              suspend_out,
  output logic [1:0]        halt_cause
);
  localparam int SRC_W = $clog2(N_SRC);

  spec_t [N_SRC-1:0] spec_q;
  logic  [N_SRC-1:0] evt, qual;
  logic              ext_evt, sw_evt, prot_evt;
  logic              win_vld;
  logic [SRC_W-1:0]  win_idx;
  spec_t             win_spec;
  cause_e            win_cause, cause_q;
  logic              halt_set;

  dbg_spec_regs #(.NS(N_SRC), .SEL_W(2)) i_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .spec_q(spec_q)
  );

  dbg_ext_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .pin_n(brk_in_n), .route_en(brk_route_en), .evt(ext_evt)
  );

  dbg_instr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .dbg_mode_en(dbg_mode_en), .instr_valid(instr_valid), .instr_word(instr_word),
    .creg_valid(creg_valid), .creg_addr(creg_addr), .sw_evt(sw_evt), .prot_evt(prot_evt)
  );

  always_comb begin
    evt           = '0;
    evt[SRC_EXT]  = ext_evt;
    evt[SRC_SW]   = sw_evt;
    evt[SRC_PROT] = prot_evt;
    for (int i = 0; i < N_SRC; i++) qual[i] = evt[i] & spec_q[i].en;
  end

  // Lowest index wins: scan from lowest priority upward
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = N_SRC-1; i >= 0; i--) begin
      if (qual[i]) begin
        win_vld = 1'b1;
        win_idx = SRC_W'(i);
      end
    end
    win_spec  = spec_q[win_idx];
    win_cause = cause_e'(win_idx + SRC_W'(1));
  end

  assign halt_set = win_vld && (win_spec.act == ACT_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_out     <= 1'b0;
      trap_req    <= 1'b0;
      irq_req     <= 1'b0;
      suspend_out <= 1'b0;
      halt        <= 1'b0;
      cause_q     <= CAUSE_NONE;
    end else begin
      brk_out     <= win_vld && (win_spec.act == ACT_BRKOUT);
      trap_req    <= win_vld && (win_spec.act == ACT_TRAP);
      irq_req     <= win_vld && (win_spec.act == ACT_IRQ);
      suspend_out <= win_vld && win_spec.susp;
      if (halt_set) begin
        halt <= 1'b1;
        if (!halt || resume) cause_q <= win_cause;
      end else if (resume) begin
        halt    <= 1'b0;
        cause_q <= CAUSE_NONE;
      end
    end
  end

  assign halt_cause = cause_q;

  assert_single_action_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({brk_out, trap_req, irq_req}));

  assert_halt_held_R9: assert property (@(posedge clk) disable iff (rst)
    (halt && !resume) |=> halt);

  assert_cause_set_R9: assert property (@(posedge clk) disable iff (rst)
    halt |-> (halt_cause != CAUSE_NONE));

  assert_cause_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !halt |-> (halt_cause == CAUSE_NONE));

  assert_susp_with_action_R4: assert property (@(posedge clk) disable iff (rst)
    suspend_out |-> (brk_out || trap_req || irq_req || halt));

endmodule

// File: tb/test_dbg_event_dispatch.sv
module test_dbg_event_dispatch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [3:0] cfg_wdata = 0;
  logic brk_in_n = 1, brk_route_en = 1, dbg_mode_en = 0;
  logic instr_valid = 0; logic [31:0] instr_word = 0;
  logic creg_valid = 0; logic [15:0] creg_addr = 0;
  logic resume = 0;
  logic brk_out, halt, trap_req, irq_req, suspend_out;
  logic [1:0] halt_cause;

  always #2 clk = ~clk;

  dbg_event_dispatch i_dbg_event_dispatch (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .brk_in_n(brk_in_n), .brk_route_en(brk_route_en), .dbg_mode_en(dbg_mode_en),
    .instr_valid(instr_valid), .instr_word(instr_word), .creg_valid(creg_valid),
    .creg_addr(creg_addr), .resume(resume), .brk_out(brk_out), .halt(halt),
    .trap_req(trap_req), .irq_req(irq_req), .suspend_out(suspend_out),
    .halt_cause(halt_cause)
  );

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R1";
  bit started = 0;

  // Reference model state
  int spec[3];
  int s_a = 1, s_b = 1, s_c = 1;
  int m_brk = 0, m_trap = 0, m_irq = 0, m_susp = 0, m_halt = 0, m_cause = 0;

  function automatic bit exempt(input logic [15:0] a);
    for (int k = 0; k < 9; k++) if (a == 16'hFD00 + 16'(4*k)) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    int ev[3];
    int win, act;
    started = 1;
    cycles++;
    if (rst) begin
      spec = '{0, 0, 0};
      s_a = 1; s_b = 1; s_c = 1;
      m_brk = 0; m_trap = 0; m_irq = 0; m_susp = 0; m_halt = 0; m_cause = 0;
    end else begin
      ev[0] = (s_b == 0 && s_c == 1 && brk_route_en) ? 1 : 0;
      ev[1] = (instr_valid && dbg_mode_en &&
               ((!instr_word[0] && instr_word[15:0] == 16'h00A0) ||
                (instr_word[0] && instr_word == 32'h0100_00A1))) ? 1 : 0;
      ev[2] = (creg_valid && !exempt(creg_addr)) ? 1 : 0;
      win = -1;
      for (int i = 2; i >= 0; i--) if (ev[i] != 0 && (spec[i] & 1) != 0) win = i;
      m_brk = 0; m_trap = 0; m_irq = 0; m_susp = 0;
      if (win >= 0) begin
        act = (spec[win] >> 1) & 3;
        m_susp = (spec[win] >> 3) & 1;
        if (act == 0) m_brk = 1;
        if (act == 2) m_trap = 1;
        if (act == 3) m_irq = 1;
      end else act = -1;
      if (act == 1) begin
        if (m_halt == 0 || resume) m_cause = win + 1;
        m_halt = 1;
      end else if (resume) begin
        m_halt = 0; m_cause = 0;
      end
      if (cfg_we && cfg_sel < 3) spec[cfg_sel] = cfg_wdata;
      s_c = s_b; s_b = s_a; s_a = brk_in_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at cycle %0d", req, phase, act, exp, cycles);
    end
  endtask

  // Compare every output on every clock, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk("R3 brk_out", brk_out, m_brk);
      chk("R3 trap_req", trap_req, m_trap);
      chk("R3 irq_req", irq_req, m_irq);
      chk("R4 suspend_out", suspend_out, m_susp);
      chk("R9 halt", halt, m_halt);
      chk("R9 halt_cause", halt_cause, m_cause);
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired expected=finish actual=hang");
    finish_run();
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [3:0] v);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = v; tick();
    cfg_we = 0;
  endtask

  task automatic sw(input logic [31:0] w);
    instr_valid = 1; instr_word = w; tick();
    instr_valid = 0; instr_word = 0;
  endtask

  task automatic acc(input logic [15:0] a);
    creg_valid = 1; creg_addr = a; tick();
    creg_valid = 0;
  endtask

  task automatic pulse_resume;
    resume = 1; tick(); resume = 0;
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick();
    // R1: explicit reset state
    chk("R1 outputs", {brk_out, halt, trap_req, irq_req, suspend_out, halt_cause}, 0);
    phase = "R8 disabled";
    dbg_mode_en = 1;
    sw(32'h0000_00A0); acc(16'h0010); tick(2);
    phase = "R2 config";
    wr(0, 4'hD);   // ext: trap + suspend
    wr(1, 4'h3);   // sw: halt
    wr(2, 4'h7);   // prot: irq
    wr(3, 4'hF);   // unused select, no effect
    phase = "R6 mode off";
    dbg_mode_en = 0; sw(32'h0000_00A0); sw(32'h0100_00A1); tick(2);
    phase = "R6 16-bit";
    dbg_mode_en = 1; sw(32'hFFFF_00A0); tick(2);
    phase = "R9 resume";
    pulse_resume(); tick();
    phase = "R6 32-bit";
    sw(32'h0100_00A1); tick(); pulse_resume();
    phase = "R6 non-matching";
    sw(32'h0000_00A1); sw(32'h0200_00A1); sw(32'h0000_00A2); tick(2);
    phase = "R7 exempt";
    for (int k = 0; k < 9; k++) acc(16'hFD00 + 16'(4*k));
    phase = "R7 protected";
    acc(16'hFD02); acc(16'hFD24); acc(16'h0000); acc(16'hFCFC); tick(2);
    phase = "R5 route off";
    brk_route_en = 0; brk_in_n = 0; tick(5); brk_in_n = 1; tick(3);
    phase = "R5 route on";
    brk_route_en = 1; brk_in_n = 0; tick(8); brk_in_n = 1; tick(3);
    phase = "R8 priority";
    brk_in_n = 0; tick(2);
    instr_valid = 1; instr_word = 32'h0000_00A0; creg_valid = 1; creg_addr = 16'h0100;
    tick(); instr_valid = 0; creg_valid = 0; brk_in_n = 1; tick(3);
    sw(32'h0000_00A0); pulse_resume();
    instr_valid = 1; instr_word = 32'h0000_00A0; creg_valid = 1; creg_addr = 16'h0100;
    tick(); instr_valid = 0; creg_valid = 0; tick(); pulse_resume();
    phase = "R9 halt twice";
    wr(0, 4'h3); wr(2, 4'hB);   // ext: halt; prot: halt + suspend
    sw(32'h0000_00A0); acc(16'h0200); tick();
    phase = "R9 resume with halt";
    brk_in_n = 0; tick(2);
    resume = 1; creg_valid = 1; creg_addr = 16'h0300; tick();
    resume = 0; creg_valid = 0; brk_in_n = 1; tick(2);
    pulse_resume(); tick();
    phase = "R8 disable";
    wr(2, 4'h6); acc(16'h0400); tick(2);
    phase = "R2 same-cycle write";
    wr(1, 4'h1);
    cfg_we = 1; cfg_sel = 1; cfg_wdata = 4'hF; instr_valid = 1; instr_word = 32'h0000_00A0;
    tick(); cfg_we = 0; instr_valid = 0; sw(32'h0000_00A0); tick(2);
    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cfg_we = (r < 8); cfg_sel = 2'($urandom_range(0, 3)); cfg_wdata = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 9) == 0) brk_in_n = ~brk_in_n;
      brk_route_en = ($urandom_range(0, 7) != 0);
      dbg_mode_en = ($urandom_range(0, 5) != 0);
      instr_valid = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 3))
        0: instr_word = 32'h0000_00A0 | (32'($urandom_range(0, 255)) << 16);
        1: instr_word = 32'h0100_00A1;
        default: instr_word = $urandom;
      endcase
      creg_valid = ($urandom_range(0, 2) == 0);
      creg_addr = ($urandom_range(0, 1) == 0) ? 16'hFD00 + 16'($urandom_range(0, 10) * 4)
                                              : 16'($urandom);
      resume = ($urandom_range(0, 9) == 0);
      tick();
    end
    cfg_we = 0; instr_valid = 0; creg_valid = 0; resume = 0;
    tick(4);
    finish_run();
  end
endmodule